// File: doc/BRIEF.md
# Snooping Duplicate-Tag Directory

This block is the coherence front end of a set-associative physical cache that shares a system bus with other masters, such as a DMA engine copying disk data into memory. It holds two identical copies of the tag directory. The CPU-side copy answers processor lookups. The bus-side copy is searched by a watcher that sees every bus write. Because the two searches never share a port, a snoop can be taken in every cycle without stalling the processor.

When another master writes to memory and the address falls in a line the cache holds, the watcher clears that line's valid bit in both copies. The next processor access to that line then misses, and the miss handler fetches the current value from memory. Writes that carry this cache's own master identifier are not snooped. Fills from the miss handler write the same tag and valid bit into both copies in one cycle. If a fill and a snoop invalidation land on the same set and way in the same cycle, the invalidation wins.

An address splits into three fields. The low `OFF_W` bits are the byte offset inside a line and are ignored. The next `SET_W` bits select the set. The remaining upper bits form the tag. Lookup and snoop results are registered and appear one cycle after the request.

Top module: `snoop_dup_tag_dir`

## Requirements
- R1: While reset is low and in the first cycle after it rises, every line is invalid and `cpu_hit` and `snp_hit` are 0. A lookup issued right after reset misses.
- R2: A fill (`fill_valid`=1 with address and way) writes the tag and sets valid for that set and way in both copies at the next edge. From then on, a CPU lookup and a snoop of that line both hit the filled way.
- R3: `cpu_hit`/`cpu_hit_way` appear one cycle after `cpu_lkp_valid`. `cpu_hit` is 1 only if a valid line in the addressed set holds the address tag, and `cpu_hit_way` is that way's number.
- R4: A bus write by a master other than this cache (`snp_master` != `SELF_ID`) that matches a valid line sets `snp_hit` one cycle later, with `snp_hit_way` giving the way.
- R5: A snoop hit clears the line in both copies. A later CPU lookup of that line misses, and a refill makes it hit again.
- R6: A bus write whose `snp_master` equals `SELF_ID` (default 0) never sets `snp_hit` and leaves the line valid.
- R7: A snoop with a different tag in the same set, or with a different set, reports no hit and leaves the cached lines valid.
- R8: If a fill and a snoop invalidation target the same set and way in one cycle, the line ends invalid. A fill to another way in that same cycle still takes effect.
- R9: Snoops are accepted on consecutive cycles, and each one invalidates its own line.
- R10: The byte-offset bits (the low `OFF_W` bits, default 4) do not affect lookups or snoops. Any byte address within a line hits.
- R11: A CPU lookup issued in the same cycle as a snoop that invalidates the same line reports the state before the invalidation (a hit). The line is invalid from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_lkp_valid | input | 1 | CPU-side lookup request |
| cpu_lkp_addr | input | ADDR_W | CPU lookup byte address |
| cpu_hit | output | 1 | Registered lookup hit |
| cpu_hit_way | output | WAY_W | Way that hit |
| fill_valid | input | 1 | Miss-handler fill into both copies |
| fill_addr | input | ADDR_W | Address of the line being filled |
| fill_way | input | WAY_W | Way chosen by replacement |
| snp_valid | input | 1 | Observed bus write |
| snp_master | input | MID_W | Identifier of the writing master |
| snp_addr | input | ADDR_W | Bus write byte address |
| snp_hit | output | 1 | Registered snoop hit, meaning the line was invalidated |
| snp_hit_way | output | WAY_W | Way invalidated |

## Verification
Two pairs of functions can meet in one cycle: a snoop invalidation with a miss fill, and a snoop invalidation with a CPU lookup. The bench drives a fill and a foreign bus write in the same clock to the same set and way, then checks with later lookups that neither the old line nor the new one survives. It repeats this with the fill aimed at a different way and checks that the fill survives. It also issues a CPU lookup and a snoop of one line together and expects the lookup to report a hit, while the next lookup misses.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [1:0] {
    SNP_IDLE = 2'd0,
    SNP_SELF = 2'd1,
    SNP_MISS = 2'd2,
    SNP_HIT  = 2'd3
  } snoop_verdict_e;

  // Extract a field of w bits starting at bit lo.
  function automatic logic [63:0] pick_bits(input logic [63:0] v,
                                            input int unsigned lo,
                                            input int unsigned w);
    logic [63:0] m;
    m = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (v >> lo) & m;
  endfunction

  // Position of the lowest set bit (0 when none).
  function automatic int unsigned low_index(input logic [63:0] v);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/sdt_tag_copy.sv
module sdt_tag_copy #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int LINES  = SETS * WAYS,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SLOT_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]   tag_eq,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              inv_en,
  input  logic [SLOT_W-1:0] inv_slot,
  output logic [LINES-1:0]  valid_flat
);

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;

  // Tag storage needs no reset: valid bits guard it.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_slot] <= wr_tag;
  end

  // Invalidate is applied after the fill so it wins on a collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (wr_en)  valid_q[wr_slot]  <= 1'b1;
      if (inv_en) valid_q[inv_slot] <= 1'b0;
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam logic [WAY_W-1:0] WI = WAY_W'(w);
      assign tag_eq[w] = (tag_q[{lk_set, WI}] == lk_tag);
    end
  endgenerate

  assign valid_flat = valid_q;

endmodule

// File: rtl/sdt_cpu_port.sv
module sdt_cpu_port #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_valid,
  input  logic [WAYS-1:0]  tag_eq,
  input  logic [WAYS-1:0]  valid_row,
  output logic             hit_q,
  output logic [WAY_W-1:0] way_q
);
  import sdt_pkg::*;

  logic [WAYS-1:0] hit_vec;
  assign hit_vec = tag_eq & valid_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      way_q <= '0;
    end else begin
      hit_q <= lkp_valid && (|hit_vec);
      way_q <= WAY_W'(low_index(64'(hit_vec)));
    end
  end

endmodule

// File: rtl/sdt_snoop_filter.sv
module sdt_snoop_filter #(
  parameter int WAYS  = 4,
  parameter int MID_W = 3,
  parameter logic [MID_W-1:0] SELF_ID = '0,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snp_valid,
  input  logic [MID_W-1:0]       snp_master,
  input  logic [WAYS-1:0]        tag_eq,
  input  logic [WAYS-1:0]        valid_row,
  output sdt_pkg::snoop_verdict_e verdict,
  output logic                   inv_en,
  output logic [WAY_W-1:0]       inv_way,
  output logic                   hit_q,
  output logic [WAY_W-1:0]       way_q
);
  import sdt_pkg::*;

  logic [WAYS-1:0] hit_vec;
  assign hit_vec = tag_eq & valid_row;

  always_comb begin
    if (!snp_valid)                verdict = SNP_IDLE;
    else if (snp_master == SELF_ID) verdict = SNP_SELF;
    else if (|hit_vec)             verdict = SNP_HIT;
    else                           verdict = SNP_MISS;
  end

  assign inv_en  = (verdict == SNP_HIT);
  assign inv_way = WAY_W'(low_index(64'(hit_vec)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      way_q <= '0;
    end else begin
      hit_q <= inv_en;
      way_q <= inv_way;
    end
  end

endmodule

// File: rtl/snoop_dup_tag_dir.sv
module snoop_dup_tag_dir #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int MID_W      = 3,
  parameter logic [MID_W-1:0] SELF_ID = '0,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int LINES  = SETS * WAYS,
  localparam int SLOT_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_lkp_valid,
  input  logic [ADDR_W-1:0] cpu_lkp_addr,
  output logic              cpu_hit,
  output logic [WAY_W-1:0]  cpu_hit_way,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              snp_valid,
  input  logic [MID_W-1:0]  snp_master,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic [WAY_W-1:0]  snp_hit_way
);
  import sdt_pkg::*;

  localparam int N_COPY = 2;   // index 0: CPU side, 1: bus side

  // Address fields
  logic [SET_W-1:0] cpu_set, snp_set, fill_set;
  logic [TAG_W-1:0] cpu_tag, snp_tag, fill_tag;

  assign cpu_set  = SET_W'(pick_bits(64'(cpu_lkp_addr), OFF_W, SET_W));
  assign cpu_tag  = TAG_W'(pick_bits(64'(cpu_lkp_addr), OFF_W + SET_W, TAG_W));
  assign snp_set  = SET_W'(pick_bits(64'(snp_addr), OFF_W, SET_W));
  assign snp_tag  = TAG_W'(pick_bits(64'(snp_addr), OFF_W + SET_W, TAG_W));
  assign fill_set = SET_W'(pick_bits(64'(fill_addr), OFF_W, SET_W));
  assign fill_tag = TAG_W'(pick_bits(64'(fill_addr), OFF_W + SET_W, TAG_W));

  // Named internal events, observed by the checker
  snoop_verdict_e     snp_verdict;
  logic               inv_en;
  logic [WAY_W-1:0]   inv_way;
  logic [SLOT_W-1:0]  inv_idx;
  logic [SLOT_W-1:0]  fill_idx;
  logic [LINES-1:0]   valid_cpu;
  logic [LINES-1:0]   valid_bus;

  assign inv_idx  = {snp_set, inv_way};
  assign fill_idx = {fill_set, fill_way};

  logic [SET_W-1:0] lk_set_a [N_COPY];
  logic [TAG_W-1:0] lk_tag_a [N_COPY];
  logic [WAYS-1:0]  tag_eq_a [N_COPY];
  logic [LINES-1:0] valid_a  [N_COPY];

  always_comb begin
    lk_set_a[0] = cpu_set;
    lk_tag_a[0] = cpu_tag;
    lk_set_a[1] = snp_set;
    lk_tag_a[1] = snp_tag;
  end

  // Identical copies: same write and invalidate traffic, separate lookup
  generate
    for (genvar c = 0; c < N_COPY; c++) begin : g_copy
      sdt_tag_copy #(
        .SETS (SETS),
        .WAYS (WAYS),
        .TAG_W(TAG_W)
      ) copy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (lk_set_a[c]),
        .lk_tag    (lk_tag_a[c]),
        .tag_eq    (tag_eq_a[c]),
        .wr_en     (fill_valid),
        .wr_slot   (fill_idx),
        .wr_tag    (fill_tag),
        .inv_en    (inv_en),
        .inv_slot  (inv_idx),
        .valid_flat(valid_a[c])
      );
    end
  endgenerate

  assign valid_cpu = valid_a[0];
  assign valid_bus = valid_a[1];

  logic [WAYS-1:0] cpu_row, bus_row;
  assign cpu_row = valid_cpu[{cpu_set, {WAY_W{1'b0}}} +: WAYS];
  assign bus_row = valid_bus[{snp_set, {WAY_W{1'b0}}} +: WAYS];

  sdt_cpu_port #(.WAYS(WAYS)) cpu_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lkp_valid(cpu_lkp_valid),
    .tag_eq   (tag_eq_a[0]),
    .valid_row(cpu_row),
    .hit_q    (cpu_hit),
    .way_q    (cpu_hit_way)
  );

  sdt_snoop_filter #(
    .WAYS   (WAYS),
    .MID_W  (MID_W),
    .SELF_ID(SELF_ID)
  ) snp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_valid (snp_valid),
    .snp_master(snp_master),
    .tag_eq    (tag_eq_a[1]),
    .valid_row (bus_row),
    .verdict   (snp_verdict),
    .inv_en    (inv_en),
    .inv_way   (inv_way),
    .hit_q     (snp_hit),
    .way_q     (snp_hit_way)
  );

endmodule

// File: rtl/sdt_checker.sv
module sdt_checker #(
  parameter int LINES  = 64,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_lkp_valid,
  input logic              cpu_hit,
  input logic              snp_hit,
  input logic              fill_valid,
  input logic [SLOT_W-1:0] fill_idx,
  input logic              inv_en,
  input logic [SLOT_W-1:0] inv_idx,
  input sdt_pkg::snoop_verdict_e snp_verdict,
  input logic              snp_valid,
  input logic [LINES-1:0]  valid_cpu,
  input logic [LINES-1:0]  valid_bus
);
  import sdt_pkg::*;

  logic [SLOT_W-1:0] inv_idx_q, fill_idx_q;
  always_ff @(posedge clk) begin
    inv_idx_q  <= inv_idx;
    fill_idx_q <= fill_idx;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (valid_cpu == '0 && !cpu_hit && !snp_hit));

  assert_copies_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_cpu == valid_bus);

  assert_fill_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(inv_en && inv_idx == fill_idx)) |=> valid_bus[fill_idx_q]);

  assert_cpu_hit_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> $past(cpu_lkp_valid));

  assert_snp_hit_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |-> $past(snp_valid));

  assert_inv_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !valid_cpu[inv_idx_q]);

  assert_self_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_verdict == SNP_SELF) |=> !snp_hit);

  assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && inv_en && inv_idx == fill_idx) |=> !valid_bus[inv_idx_q]);

endmodule

bind snoop_dup_tag_dir sdt_checker #(
  .LINES (LINES),
  .SLOT_W(SLOT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_lkp_valid(cpu_lkp_valid),
  .cpu_hit      (cpu_hit),
  .snp_hit      (snp_hit),
  .fill_valid   (fill_valid),
  .fill_idx     (fill_idx),
  .inv_en       (inv_en),
  .inv_idx      (inv_idx),
  .snp_verdict  (snp_verdict),
  .snp_valid    (snp_valid),
  .valid_cpu    (valid_cpu),
  .valid_bus    (valid_bus)
);

// File: tb/snoop_dup_tag_dir_tb_top.sv
`timescale 1ns/1ps
module snoop_dup_tag_dir_tb_top;

  localparam int ADDR_W = 32;
  localparam int WAY_W  = 2;
  localparam int MID_W  = 3;
  localparam logic [MID_W-1:0] SELF = 3'd0;
  localparam logic [MID_W-1:0] DMA  = 3'd2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_lkp_valid = 1'b0;
  logic [ADDR_W-1:0] cpu_lkp_addr = '0;
  logic              cpu_hit;
  logic [WAY_W-1:0]  cpu_hit_way;
  logic              fill_valid = 1'b0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [WAY_W-1:0]  fill_way = '0;
  logic              snp_valid = 1'b0;
  logic [MID_W-1:0]  snp_master = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              snp_hit;
  logic [WAY_W-1:0]  snp_hit_way;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  snoop_dup_tag_dir dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_lkp_valid(cpu_lkp_valid), .cpu_lkp_addr(cpu_lkp_addr),
    .cpu_hit(cpu_hit), .cpu_hit_way(cpu_hit_way),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
    .snp_valid(snp_valid), .snp_master(snp_master), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .snp_hit_way(snp_hit_way)
  );

  // Address: tag above bit 8, set in bits 7:4, offset in bits 3:0
  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return (32'(tag) << 8) | (32'(set & 15) << 4) | 32'(off & 15);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Advance one clock: inputs set before are sampled, then cleared.
  task automatic step();
    @(negedge clk);
    cpu_lkp_valid = 1'b0;
    fill_valid    = 1'b0;
    snp_valid     = 1'b0;
  endtask

  task automatic do_fill(input logic [31:0] a, input int way);
    fill_valid = 1'b1; fill_addr = a; fill_way = WAY_W'(way);
    step();
  endtask

  task automatic look(input string req, input logic [31:0] a, input int eh, input int ew);
    cpu_lkp_valid = 1'b1; cpu_lkp_addr = a;
    step();
    chk(req, "cpu_hit", int'(cpu_hit), eh);
    if (eh != 0) chk(req, "cpu_hit_way", int'(cpu_hit_way), ew);
  endtask

  task automatic snoop(input string req, input logic [31:0] a, input logic [MID_W-1:0] m,
                       input int eh, input int ew);
    snp_valid = 1'b1; snp_addr = a; snp_master = m;
    step();
    chk(req, "snp_hit", int'(snp_hit), eh);
    if (eh != 0) chk(req, "snp_hit_way", int'(snp_hit_way), ew);
  endtask

  task automatic t_reset();
    chk("R1", "cpu_hit after reset", int'(cpu_hit), 0);
    chk("R1", "snp_hit after reset", int'(snp_hit), 0);
    look("R1", mk(5, 2, 0), 0, 0);
    snoop("R1", mk(5, 2, 0), DMA, 0, 0);
  endtask

  task automatic t_fill_lookup();
    do_fill(mk('h12, 3, 0), 1);
    look("R2", mk('h12, 3, 0), 1, 1);
    look("R10", mk('h12, 3, 15), 1, 1);
    look("R3", mk('h13, 3, 0), 0, 0);
    look("R3", mk('h12, 4, 0), 0, 0);
  endtask

  task automatic t_self();
    snoop("R6", mk('h12, 3, 4), SELF, 0, 0);
    look("R6", mk('h12, 3, 0), 1, 1);
  endtask

  task automatic t_miss();
    snoop("R7", mk('h99, 3, 0), DMA, 0, 0);
    snoop("R7", mk('h12, 6, 0), DMA, 0, 0);
    look("R7", mk('h12, 3, 0), 1, 1);
  endtask

  task automatic t_invalidate();
    snoop("R4", mk('h12, 3, 8), DMA, 1, 1);
    look("R5", mk('h12, 3, 0), 0, 0);
    do_fill(mk('h12, 3, 0), 2);
    look("R5", mk('h12, 3, 0), 1, 2);
    snoop("R2", mk('h12, 3, 0), DMA, 1, 2);
  endtask

  task automatic t_same_cycle_lookup();
    do_fill(mk('h40, 5, 0), 0);
    cpu_lkp_valid = 1'b1; cpu_lkp_addr = mk('h40, 5, 0);
    snp_valid = 1'b1; snp_addr = mk('h40, 5, 0); snp_master = DMA;
    step();
    chk("R11", "cpu_hit same cycle", int'(cpu_hit), 1);
    chk("R11", "snp_hit same cycle", int'(snp_hit), 1);
    look("R11", mk('h40, 5, 0), 0, 0);
  endtask

  task automatic t_collision();
    do_fill(mk('h70, 7, 0), 3);
    snp_valid = 1'b1; snp_addr = mk('h70, 7, 0); snp_master = DMA;
    fill_valid = 1'b1; fill_addr = mk('h71, 7, 0); fill_way = 2'd3;
    step();
    chk("R8", "snp_hit at collision", int'(snp_hit), 1);
    chk("R8", "snp_hit_way at collision", int'(snp_hit_way), 3);
    look("R8", mk('h70, 7, 0), 0, 0);
    look("R8", mk('h71, 7, 0), 0, 0);
    do_fill(mk('h80, 8, 0), 0);
    snp_valid = 1'b1; snp_addr = mk('h80, 8, 0); snp_master = DMA;
    fill_valid = 1'b1; fill_addr = mk('h81, 8, 0); fill_way = 2'd2;
    step();
    chk("R8", "snp_hit other-way case", int'(snp_hit), 1);
    look("R8", mk('h80, 8, 0), 0, 0);
    look("R8", mk('h81, 8, 0), 1, 2);
  endtask

  task automatic t_back_to_back();
    do_fill(mk('h90, 9, 0), 0);
    do_fill(mk('hA0, 10, 0), 1);
    snp_valid = 1'b1; snp_addr = mk('h90, 9, 0); snp_master = DMA;
    @(negedge clk);
    chk("R9", "first snoop hit", int'(snp_hit), 1);
    snp_addr = mk('hA0, 10, 0); snp_master = 3'd5;
    step();
    chk("R9", "second snoop hit", int'(snp_hit), 1);
    chk("R9", "second snoop way", int'(snp_hit_way), 1);
    look("R9", mk('h90, 9, 0), 0, 0);
    look("R9", mk('hA0, 10, 0), 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_lookup();
    t_self();
    t_miss();
    t_invalidate();
    t_same_cycle_lookup();
    t_collision();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule